// File: doc/BRIEF.md
# SMBus Control and Handshake Engine

This block keeps the five control flags that software uses to run a two-wire SMBus/I2C controller: enable, start request, stop request, interrupt flag and acknowledge enable. Each cycle it turns those flags into bus actions. Master START, repeated START and STOP requests come out as single-cycle pulses. SCL is held low while the interrupt flag is pending, and SDA is pulled low in the acknowledge slot. The byte shifter, the pin drivers and the bit timer sit next to this block. They report bus events to it on single-cycle strobe inputs.

Software writes the whole flag word through a simple write strobe and can read the word back at any time. Hardware may change two of the flags. It sets the interrupt flag when the engine reaches a state that needs attention, and it clears the stop request when a STOP is seen on the bus. Every output is registered and changes on the clock edge after the inputs that cause it.

Top module: `smbc_engine`

## Requirements
- R1: After synchronous reset the flag word reads 0 and every request, hold, acknowledge and interrupt output is 0. The flag word layout is: bit 0 enable, bit 1 start request, bit 2 stop request, bit 3 interrupt flag, bit 4 acknowledge enable.
- R2: While enable is 0 the engine drops to the idle, not-addressed state and forgets that the bus is busy. A start request made after enabling again issues START at once.
- R3: Hardware sets the interrupt flag on these events: entering master mode, issuing a repeated START, a byte done in master mode or while addressed, becoming addressed, and a STOP while addressed. A software write of 0 clears it and a write of 1 sets it.
- R4: If software writes 0 to the interrupt flag in the same cycle as a hardware set, the flag ends at 1.
- R5: The interrupt output is the interrupt flag ANDed with the interrupt-enable input.
- R6: SCL hold is 1 only when the interrupt flag is 1, the engine is enabled and SCL is reported low. A high SCL is never held.
- R7: A start request issues a START pulse and enters master mode when the bus is free. If the bus is busy, the engine waits until a STOP is seen or the bus-free timeout input is raised, and then issues the START.
- R8: In master mode, a start request after at least one completed byte issues one repeated START pulse.
- R9: In master mode a stop request issues one STOP pulse. A STOP seen on the bus clears the stop-request flag.
- R10: A stop request while not master drives no STOP pulse. It returns the engine to the not-addressed state, and the bus stays busy, so a later start request waits for a real STOP.
- R11: During the acknowledge slot, SDA is pulled low only when the engine is addressed and acknowledge enable is 1.
- R12: With acknowledge enable at 0, own-address and general-call matches are ignored: the engine does not become addressed and does not set the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the flag word |
| reg_wdata | input | 5 | Flag word to write |
| reg_rdata | output | 5 | Current flag word |
| bus_start_seen | input | 1 | START detected on the bus (strobe) |
| bus_stop_seen | input | 1 | STOP detected on the bus (strobe) |
| byte_done | input | 1 | A byte and its acknowledge completed (strobe) |
| own_addr_hit | input | 1 | Received address matches own address (strobe) |
| gen_call_hit | input | 1 | General-call address received (strobe) |
| bus_free | input | 1 | Bus-idle timeout expired (strobe) |
| scl_is_low | input | 1 | SCL line currently low |
| ack_phase | input | 1 | Current bit is the acknowledge slot |
| irq_enable | input | 1 | Interrupt enable |
| req_start | output | 1 | Issue START (pulse) |
| req_rstart | output | 1 | Issue repeated START (pulse) |
| req_stop | output | 1 | Issue STOP (pulse) |
| scl_hold | output | 1 | Hold SCL low |
| sda_ack_low | output | 1 | Pull SDA low in the acknowledge slot |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the fake STOP in slave mode. The engine must leave the addressed state without releasing the bus, and nothing on the ports shows the busy marker directly. The stimulus first reports a START so the bus is busy. It then addresses the engine with acknowledge enable set and writes the stop request. After that it shows that the acknowledge slot is no longer driven and that a new start request stays blocked until a STOP strobe arrives. The same-cycle race between a software clear of the interrupt flag and a hardware set is produced by writing the word in the same cycle as a byte-done strobe.

// File: rtl/smbc_pkg.sv
package smbc_pkg;
  localparam int CTRL_W = 5;
  localparam int B_EN  = 0;
  localparam int B_STA = 1;
  localparam int B_STO = 2;
  localparam int B_IRQ = 3;
  localparam int B_ACK = 4;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    M_IDLE  = 3'd0,
    M_WAIT  = 3'd1,
    M_MAST  = 3'd2,
    M_STOPG = 3'd3,
    M_SLV   = 3'd4
  } mode_e;
endpackage

// File: rtl/smbc_flags.sv
module smbc_flags
  import smbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              hw_irq_set,
  input  logic              hw_sto_clr,
  output logic [CTRL_W-1:0] flags_q,
  output logic              irq_next
);
  logic [CTRL_W-1:0] flags_n;

  always_comb begin
    flags_n = flags_q;
    if (wr_en) flags_n = wr_data;
    if (hw_sto_clr) flags_n[B_STO] = 1'b0;
    if (hw_irq_set) flags_n[B_IRQ] = 1'b1;
  end

  assign irq_next = flags_n[B_IRQ];

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_n;
  end

  // R3: the flag only falls after a software write of 0
  a_r3_irq_clear_by_write: assert property (@(posedge clk) disable iff (rst)
    $fell(flags_q[B_IRQ]) |-> $past(wr_en && !wr_data[B_IRQ]));
  // R4: a hardware set always lands
  a_r4_hw_set_wins: assert property (@(posedge clk) disable iff (rst)
    hw_irq_set |=> flags_q[B_IRQ]);
  // R9: a bus STOP clears the stop request
  a_r9_stop_cleared: assert property (@(posedge clk) disable iff (rst)
    hw_sto_clr |=> !flags_q[B_STO]);
endmodule

// File: rtl/smbc_seq.sv
module smbc_seq
  import smbc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sta,
  input  logic sto,
  input  logic ack_en,
  input  logic evt_start,
  input  logic evt_stop,
  input  logic evt_byte,
  input  logic evt_own,
  input  logic evt_gcall,
  input  logic bus_idle,
  output logic req_start,
  output logic req_rstart,
  output logic req_stop,
  output logic addressed,
  output logic irq_set,
  output logic sto_clr
);
  mode_e mode_q, mode_n;
  logic  busy_q, busy_n;
  logic  bytes_q, bytes_n;
  logic  st_n, rs_n, sp_n;

  always_comb begin
    mode_n  = mode_q;
    busy_n  = busy_q;
    bytes_n = bytes_q;
    st_n    = 1'b0;
    rs_n    = 1'b0;
    sp_n    = 1'b0;
    irq_set = 1'b0;
    if (evt_start) busy_n = 1'b1;
    if (evt_stop || bus_idle) busy_n = 1'b0;
    if (!en) begin
      mode_n  = M_IDLE;
      busy_n  = 1'b0;
      bytes_n = 1'b0;
    end else begin
      unique case (mode_q)
        M_IDLE, M_SLV: begin
          if (sta) begin
            if (!busy_q) begin
              mode_n = M_MAST; st_n = 1'b1; busy_n = 1'b1;
              bytes_n = 1'b0; irq_set = 1'b1;
            end else begin
              mode_n = M_WAIT;
            end
          end else if (sto) begin
            mode_n = M_IDLE;
          end else if (mode_q == M_IDLE) begin
            if (ack_en && (evt_own || evt_gcall)) begin
              mode_n = M_SLV; irq_set = 1'b1;
            end
          end else begin
            if (evt_byte) irq_set = 1'b1;
            if (evt_stop) begin
              mode_n = M_IDLE; irq_set = 1'b1;
            end
          end
        end
        M_WAIT: begin
          if (!sta) begin
            mode_n = M_IDLE;
          end else if (!busy_q) begin
            mode_n = M_MAST; st_n = 1'b1; busy_n = 1'b1;
            bytes_n = 1'b0; irq_set = 1'b1;
          end
        end
        M_MAST: begin
          if (sto) begin
            sp_n = 1'b1; mode_n = M_STOPG;
          end else if (sta && bytes_q) begin
            rs_n = 1'b1; bytes_n = 1'b0; irq_set = 1'b1;
          end else if (evt_byte) begin
            bytes_n = 1'b1; irq_set = 1'b1;
          end
        end
        M_STOPG: begin
          if (evt_stop) mode_n = M_IDLE;
        end
        default: mode_n = M_IDLE;
      endcase
    end
  end

  assign sto_clr   = evt_stop;
  assign addressed = (mode_q == M_SLV);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= M_IDLE;
      busy_q     <= 1'b0;
      bytes_q    <= 1'b0;
      req_start  <= 1'b0;
      req_rstart <= 1'b0;
      req_stop   <= 1'b0;
    end else begin
      mode_q     <= mode_n;
      busy_q     <= busy_n;
      bytes_q    <= bytes_n;
      req_start  <= st_n;
      req_rstart <= rs_n;
      req_stop   <= sp_n;
    end
  end

  // R7: START only on a free bus
  a_r7_start_on_free: assert property (@(posedge clk) disable iff (rst)
    req_start |-> $past(!busy_q));
  // R8: repeated START only after a byte
  a_r8_rstart_after_byte: assert property (@(posedge clk) disable iff (rst)
    req_rstart |-> $past(bytes_q));
  // R9 / R10: STOP pulses only from master mode
  a_r10_stop_master_only: assert property (@(posedge clk) disable iff (rst)
    req_stop |-> $past(mode_q == M_MAST));
  // R10: a fake STOP keeps the bus busy
  a_r10_keep_busy: assert property (@(posedge clk) disable iff (rst)
    (en && mode_q == M_SLV && sto && !sta && busy_q && !evt_stop && !bus_idle)
      |=> (busy_q && mode_q == M_IDLE));
  // R2: disabled engine is idle with no bus state
  a_r2_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> (mode_q == M_IDLE && !busy_q));
endmodule

// File: rtl/smbc_pins.sv
module smbc_pins (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic irq_next,
  input  logic ack_en,
  input  logic addressed,
  input  logic scl_low,
  input  logic ack_slot,
  input  logic irq_en,
  output logic scl_hold,
  output logic sda_ack_low,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_hold    <= 1'b0;
      sda_ack_low <= 1'b0;
      irq         <= 1'b0;
    end else begin
      scl_hold    <= en && irq_next && scl_low;
      sda_ack_low <= en && addressed && ack_en && ack_slot;
      irq         <= irq_next && irq_en;
    end
  end

  // R6: never hold a high SCL
  a_r6_hold_only_low: assert property (@(posedge clk) disable iff (rst)
    scl_hold |-> $past(scl_low));
  // R11: ACK only in the slot and when addressed
  a_r11_ack_in_slot: assert property (@(posedge clk) disable iff (rst)
    sda_ack_low |-> $past(ack_slot && addressed));
  // R5: interrupt gated by enable input
  a_r5_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en));
endmodule

// File: rtl/smbc_engine.sv
module smbc_engine
  import smbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic              bus_start_seen,
  input  logic              bus_stop_seen,
  input  logic              byte_done,
  input  logic              own_addr_hit,
  input  logic              gen_call_hit,
  input  logic              bus_free,
  input  logic              scl_is_low,
  input  logic              ack_phase,
  input  logic              irq_enable,
  output logic              req_start,
  output logic              req_rstart,
  output logic              req_stop,
  output logic              scl_hold,
  output logic              sda_ack_low,
  output logic              irq
);
  logic [CTRL_W-1:0] flags;
  logic irq_next, irq_set, sto_clr, addressed;

  smbc_flags u_flags (
    .clk(clk), .rst(rst), .wr_en(reg_we), .wr_data(reg_wdata),
    .hw_irq_set(irq_set), .hw_sto_clr(sto_clr),
    .flags_q(flags), .irq_next(irq_next)
  );

  smbc_seq u_seq (
    .clk(clk), .rst(rst),
    .en(flags[B_EN]), .sta(flags[B_STA]), .sto(flags[B_STO]), .ack_en(flags[B_ACK]),
    .evt_start(bus_start_seen), .evt_stop(bus_stop_seen), .evt_byte(byte_done),
    .evt_own(own_addr_hit), .evt_gcall(gen_call_hit), .bus_idle(bus_free),
    .req_start(req_start), .req_rstart(req_rstart), .req_stop(req_stop),
    .addressed(addressed), .irq_set(irq_set), .sto_clr(sto_clr)
  );

  smbc_pins u_pins (
    .clk(clk), .rst(rst), .en(flags[B_EN]), .irq_next(irq_next),
    .ack_en(flags[B_ACK]), .addressed(addressed), .scl_low(scl_is_low),
    .ack_slot(ack_phase), .irq_en(irq_enable),
    .scl_hold(scl_hold), .sda_ack_low(sda_ack_low), .irq(irq)
  );

  assign reg_rdata = flags;
endmodule

// File: tb/test_smbc_engine.sv
`timescale 1ns/1ps
module test_smbc_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we = 0;
  logic [4:0] wd = 0;
  logic [4:0] rd;
  logic ss = 0, sp = 0, bd = 0, am = 0, gc = 0, bi = 0, sl = 0, as = 0, ie = 0;
  logic st, rs, so, hold, ack, irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  smbc_engine i_smbc_engine (
    .clk(clk), .rst(rst), .reg_we(we), .reg_wdata(wd), .reg_rdata(rd),
    .bus_start_seen(ss), .bus_stop_seen(sp), .byte_done(bd),
    .own_addr_hit(am), .gen_call_hit(gc), .bus_free(bi),
    .scl_is_low(sl), .ack_phase(as), .irq_enable(ie),
    .req_start(st), .req_rstart(rs), .req_stop(so),
    .scl_hold(hold), .sda_ack_low(ack), .irq(irq)
  );

  typedef struct packed {
    logic we; logic [4:0] wd;
    logic ss, sp, bd, am, gc, bi, sl, as, ie;
    logic [10:0] exp;
  } vec_t;

  // exp = {start, rstart, stop, hold, ack, irq, rdata[4:0]}
  // rdata bits: 4 ack_en, 3 irq flag, 2 stop, 1 start, 0 enable
  localparam int NV = 11;
  localparam vec_t TAB [NV] = '{
    '{1'b1, 5'b10001, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 11'b000000_10001}, // enable
    '{1'b1, 5'b10011, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 11'b000000_10011}, // start req
    '{1'b0, 5'b00000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 11'b100000_11011}, // R7 free START, R3
    '{1'b0, 5'b00000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 11'b000101_11011}, // R6 hold, R5
    '{1'b1, 5'b10001, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 11'b000000_10001}, // R3 clear
    '{1'b0, 5'b00000, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 11'b000101_11001}, // R3 byte
    '{1'b1, 5'b10011, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 11'b000001_11011}, // R4 race, R6 high
    '{1'b0, 5'b00000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 11'b010001_11011}, // R8 rstart
    '{1'b1, 5'b10101, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 11'b000000_10101}, // stop req
    '{1'b0, 5'b00000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 11'b001000_10101}, // R9 STOP
    '{1'b0, 5'b00000, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 11'b000000_10001}  // R9 clear
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_in();
    we = 0; wd = 0; ss = 0; sp = 0; bd = 0; am = 0; gc = 0; bi = 0; sl = 0; as = 0;
  endtask

  task automatic wr(logic [4:0] v);
    we = 1; wd = v; step(); we = 0;
  endtask

  task automatic do_reset();
    idle_in(); ie = 0; rst = 1; step(); step(); rst = 0;
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    check("R1 outputs", {st, rs, so, hold, ack, irq}, 6'b0);
    check("R1 flags", rd, 5'b0);

    // master flow through the table
    for (int k = 0; k < NV; k++) begin
      we = TAB[k].we; wd = TAB[k].wd; ss = TAB[k].ss; sp = TAB[k].sp; bd = TAB[k].bd;
      am = TAB[k].am; gc = TAB[k].gc; bi = TAB[k].bi; sl = TAB[k].sl; as = TAB[k].as;
      ie = TAB[k].ie;
      step();
      check($sformatf("table row %0d (R3-R9 flow)", k),
            {st, rs, so, hold, ack, irq, rd}, TAB[k].exp);
    end
    idle_in();

    // R7: busy bus, START after bus-free timeout
    do_reset();
    wr(5'b10001);
    ss = 1; step(); ss = 0;
    wr(5'b10011);
    step(); step();
    check("R7 waits while busy", st, 1'b0);
    bi = 1; step(); bi = 0;
    check("R7 no START on timeout edge", st, 1'b0);
    step();
    check("R7 START after free", st, 1'b1);

    // R12 / R11 / R10: slave side
    do_reset();
    ie = 1;
    wr(5'b00001);
    ss = 1; step(); ss = 0;
    am = 1; step(); am = 0;
    check("R12 own addr ignored flags", rd, 5'b00001);
    check("R12 own addr no irq", irq, 1'b0);
    gc = 1; step(); gc = 0;
    check("R12 gen call ignored", rd, 5'b00001);
    as = 1; step(); as = 0;
    check("R12 no ack when ignored", ack, 1'b0);
    wr(5'b10001);
    am = 1; step(); am = 0;
    check("R3 irq on addressing", rd, 5'b11001);
    as = 1; step(); as = 0;
    check("R11 ack driven", ack, 1'b1);
    wr(5'b10101);
    step();
    check("R10 no STOP pulse", so, 1'b0);
    check("R10 stop flag kept", rd, 5'b10101);
    as = 1; step(); as = 0;
    check("R10 not addressed after fake stop", ack, 1'b0);
    wr(5'b10011);
    step(); step(); step();
    check("R10 bus still busy", st, 1'b0);
    sp = 1; step(); sp = 0;
    check("R10 no START on stop edge", st, 1'b0);
    step();
    check("R10 START after real STOP", st, 1'b1);

    // R2: disable forgets bus state; R5 gating
    do_reset();
    wr(5'b10001);
    ss = 1; step(); ss = 0;
    wr(5'b10000);
    step();
    check("R2 outputs quiet when disabled", {st, rs, so, hold, ack}, 5'b0);
    wr(5'b10011);
    step();
    check("R2 START after re-enable", st, 1'b1);
    ie = 0; step();
    check("R5 irq masked", irq, 1'b0);
    check("R5 flag set", rd[3], 1'b1);
    ie = 1; step();
    check("R5 irq passes", irq, 1'b1);
    sl = 1; step(); sl = 0;
    check("R6 hold when low", hold, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule